// File: doc/BRIEF.md
# Carry-Free Decimal Digit Arithmetic Unit

This unit works on packed decimal operands of `NDIG` digits. Each digit position is treated as a residue modulo 10 of its own, and no carry or borrow ever moves from one position to the next. It offers four operations:

- **Addition** adds two operands position by position modulo 10.
- **Negation** replaces each digit d with (10 − d) mod 10.
- **Subtraction** adds the negated second operand to the first.
- **Multiplication** takes the full convolution of the two digit strings and reduces every coefficient modulo 10. The result has 2·NDIG−1 digits.

Addition, subtraction and negation are combinational lanes. Their result is registered in one cycle. Multiplication is sequential. Each cycle takes one digit of the multiplier, multiplies it by the whole multiplicand one digit at a time, and adds the products modulo 10 into an accumulator shifted by that digit's position. After NDIG rows the product is final.

A request is made by pulsing `start` while the unit is idle. The unit answers with a one-cycle `done` pulse. A request that carries any nibble above 9 in either operand is rejected: `err` is raised together with `done`.

The control states are:

| State | Meaning |
|---|---|
| IDLE | Waiting for a request |
| MUL | Accumulating one partial-product row per cycle |
| DONE | Presents `done` for one cycle |

The transitions are:

| Transition | Condition |
|---|---|
| IDLE→DONE (quick path) | add, subtract or negate, or a rejected request |
| IDLE→MUL (multiply launch) | valid multiply request |
| MUL→MUL (next row) | row index below NDIG−1 |
| MUL→DONE (last row) | row index equals NDIG−1 |
| DONE→IDLE (release) | always, after one cycle |

Top module: `cl_dec_unit`

## Requirements
- R1: With `op`=2'b00, result digit i (bits 4i+3..4i, digit 0 least significant) equals (a_i + b_i) mod 10 for i < NDIG, and all higher result digits are 0.
- R2: With `op`=2'b01, result digit i equals (a_i + (10 − b_i) mod 10) mod 10 for i < NDIG, and all higher digits are 0.
- R3: With `op`=2'b10, result digit i equals (10 − a_i) mod 10 for i < NDIG, and all higher digits are 0. Adding a to its negation gives 0 in every digit.
- R4: With `op`=2'b11, result digit k (0 ≤ k < 2·NDIG−1) equals the sum of a_i·b_j over all i+j=k, taken mod 10. Every result digit is in 0..9.
- R5: `done` first shows 1 cycle after the edge that samples `start` for add, subtract and negate, and NDIG+1 cycles after it for multiply. `busy` is high from that edge until `done` falls.
- R6: Swapping a and b does not change the result of add or multiply.
- R7: Each product digit agrees with the convolution taken separately mod 2 and mod 5 (digit mod 2 and digit mod 5).
- R8: If any nibble of a or b exceeds 9, `err` and `done` are high 1 cycle after the request and `result` keeps its previous value.
- R9: A `start` while the unit is busy is ignored. The running operation finishes with its own result and timing.
- R10: `done` lasts one cycle, and `result` changes only when `done` becomes high.
- R11: After reset, `busy`, `done` and `err` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| op | input | 2 | 00 add, 01 subtract, 10 negate, 11 multiply |
| a | input | 4·NDIG | First operand, packed decimal digits |
| b | input | 4·NDIG | Second operand, packed decimal digits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (non-decimal nibble), valid with `done` |
| result | output | 4·(2·NDIG−1) | Result digits |

## Verification
The assertions check the following on every cycle:
- `done` is a single-cycle pulse.
- `result` moves only while `done` is high, and never moves on a rejected request.
- Every result digit is decimal.
- `busy` stays up until the completion pulse.

Only the bench scenarios can show the rest:
- The per-digit values of add, subtract, negate and convolution, checked against an independent nested-loop model.
- The operand-order symmetry.
- The agreement of product digits with the separate mod 2 and mod 5 convolutions.
- The exact latencies.
- That a request made while busy is dropped.

// File: rtl/cl_dec_pkg.sv
`timescale 1ns/1ps
package cl_dec_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_NEG = 2'b10,
        OP_MUL = 2'b11
    } op_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_MUL  = 2'b01,
        S_DONE = 2'b10
    } state_t;

    // sum of two decimal digits, wrapped into 0..9
    function automatic logic [3:0] add_m10(input logic [3:0] x, input logic [3:0] y);
        logic [4:0] s;
        logic [4:0] t;
        s = {1'b0, x} + {1'b0, y};
        t = s - 5'd10;
        return (s >= 5'd10) ? t[3:0] : s[3:0];
    endfunction

    // ten's complement of one digit
    function automatic logic [3:0] neg_m10(input logic [3:0] x);
        return (x == 4'd0) ? 4'd0 : 4'd10 - x;
    endfunction

    // digit product, wrapped into 0..9
    function automatic logic [3:0] mul_m10(input logic [3:0] x, input logic [3:0] y);
        logic [7:0] p;
        logic [7:0] r;
        p = {4'd0, x} * {4'd0, y};
        r = p % 8'd10;
        return r[3:0];
    endfunction

    // one lane of the quick operations
    function automatic logic [3:0] lane_m10(input op_t o, input logic [3:0] x, input logic [3:0] y);
        logic [3:0] v;
        unique case (o)
            OP_ADD:  v = add_m10(x, y);
            OP_SUB:  v = add_m10(x, neg_m10(y));
            OP_NEG:  v = neg_m10(x);
            default: v = 4'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cl_bcd_check.sv
`timescale 1ns/1ps
module cl_bcd_check #(
    parameter int NDIG = 8
) (
    input  logic [4*NDIG-1:0] x,
    output logic              ok
);
    logic [NDIG-1:0] dig_ok;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign dig_ok[i] = (x[4*i +: 4] <= 4'd9);
    end

    assign ok = &dig_ok;
endmodule

// File: rtl/cl_lane_addsub.sv
`timescale 1ns/1ps
module cl_lane_addsub
    import cl_dec_pkg::*;
#(
    parameter int NDIG = 8
) (
    input  op_t               op,
    input  logic [4*NDIG-1:0] a,
    input  logic [4*NDIG-1:0] b,
    output logic [4*NDIG-1:0] y
);
    for (genvar i = 0; i < NDIG; i++) begin : g_lane
        assign y[4*i +: 4] = lane_m10(op, a[4*i +: 4], b[4*i +: 4]);
    end
endmodule

// File: rtl/cl_mac_row.sv
`timescale 1ns/1ps
module cl_mac_row
    import cl_dec_pkg::*;
#(
    parameter int NDIG = 8,
    parameter int CW   = 3
) (
    input  logic [4*(2*NDIG-1)-1:0] acc_in,
    input  logic [4*NDIG-1:0]       mcand,
    input  logic [3:0]              digit,
    input  logic [CW-1:0]           row,
    output logic [4*(2*NDIG-1)-1:0] acc_out
);
    localparam int RDIG = 2*NDIG - 1;

    for (genvar k = 0; k < RDIG; k++) begin : g_pos
        logic [3:0] prod_k;
        logic [3:0] sum_k;

        always_comb begin
            int p;
            int pc;
            p  = k - int'(row);
            pc = (p >= 0 && p < NDIG) ? p : 0;
            if (p >= 0 && p < NDIG) begin
                prod_k = mul_m10(mcand[4*pc +: 4], digit);
            end else begin
                prod_k = 4'd0;
            end
            sum_k = add_m10(acc_in[4*k +: 4], prod_k);
        end

        assign acc_out[4*k +: 4] = sum_k;
    end
endmodule

// File: rtl/cl_dec_unit.sv
`timescale 1ns/1ps
module cl_dec_unit
    import cl_dec_pkg::*;
#(
    parameter int NDIG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              op,
    input  logic [4*NDIG-1:0]       a,
    input  logic [4*NDIG-1:0]       b,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [4*(2*NDIG-1)-1:0] result
);
    localparam int OW   = 4*NDIG;
    localparam int RDIG = 2*NDIG - 1;
    localparam int RW   = 4*RDIG;
    localparam int CW   = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [CW-1:0] LAST_ROW = CW'(NDIG - 1);

    state_t        state_q, state_d;
    logic [CW-1:0] row_q;
    logic [OW-1:0] a_q, b_q;
    logic [RW-1:0] acc_q, acc_nx, res_q;
    logic          err_q;
    logic          ok_a, ok_b, req_ok;
    logic [OW-1:0] lane_y;
    op_t           op_v;

    assign op_v   = op_t'(op);
    assign req_ok = ok_a && ok_b;

    cl_bcd_check #(.NDIG(NDIG)) i_chk_a (.x(a), .ok(ok_a));
    cl_bcd_check #(.NDIG(NDIG)) i_chk_b (.x(b), .ok(ok_b));

    cl_lane_addsub #(.NDIG(NDIG)) i_lanes (
        .op (op_v),
        .a  (a),
        .b  (b),
        .y  (lane_y)
    );

    cl_mac_row #(.NDIG(NDIG), .CW(CW)) i_row (
        .acc_in  (acc_q),
        .mcand   (a_q),
        .digit   (b_q[4*row_q +: 4]),
        .row     (row_q),
        .acc_out (acc_nx)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (!req_ok)               state_d = S_DONE;
                    else if (op_v == OP_MUL)   state_d = S_MUL;
                    else                       state_d = S_DONE;
                end
            end
            S_MUL:   if (row_q == LAST_ROW) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
            res_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (!req_ok) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q <= 1'b0;
                            if (op_v == OP_MUL) begin
                                a_q   <= a;
                                b_q   <= b;
                                acc_q <= '0;
                                row_q <= '0;
                            end else begin
                                res_q <= {{(RW-OW){1'b0}}, lane_y};
                            end
                        end
                    end
                end
                S_MUL: begin
                    acc_q <= acc_nx;
                    row_q <= row_q + 1'b1;
                    if (row_q == LAST_ROW) res_q <= acc_nx;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != S_IDLE);
        done   = (state_q == S_DONE);
        err    = (state_q == S_DONE) && err_q;
        result = res_q;
    end
endmodule

// File: rtl/cl_dec_unit_chk.sv
`timescale 1ns/1ps
module cl_dec_unit_chk #(
    parameter int NDIG = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    done,
    input logic                    err,
    input logic [4*(2*NDIG-1)-1:0] result
);
    localparam int RDIG = 2*NDIG - 1;

    function automatic logic all_dec(input logic [4*(2*NDIG-1)-1:0] v);
        for (int i = 0; i < RDIG; i++) begin
            if (v[4*i +: 4] > 4'd9) return 1'b0;
        end
        return 1'b1;
    endfunction

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r8_err_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(result));

    a_r4_dec_digits: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> all_dec(result));

    a_r5_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind cl_dec_unit cl_dec_unit_chk #(.NDIG(NDIG)) i_cl_dec_unit_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .result (result)
);

// File: tb/test_cl_dec_unit.sv
`timescale 1ns/1ps
module test_cl_dec_unit;
    localparam int N  = 8;
    localparam int RD = 2*N - 1;
    localparam int RW = 4*RD;
    localparam int NV = 10;

    // {op, a, b}
    localparam logic [65:0] VEC [NV] = '{
        {2'b00, 32'h1234_5678, 32'h8765_4321},
        {2'b00, 32'h9999_9999, 32'h0000_0001},
        {2'b01, 32'h5555_5555, 32'h1234_9876},
        {2'b01, 32'h0000_0000, 32'h9081_7263},
        {2'b10, 32'h0123_4567, 32'h0000_0000},
        {2'b10, 32'h9000_0005, 32'h1111_1111},
        {2'b11, 32'h0000_0009, 32'h0000_0009},
        {2'b11, 32'h0000_0011, 32'h0000_0011},
        {2'b11, 32'h9999_9999, 32'h9999_9999},
        {2'b11, 32'h1357_2468, 32'h8642_7531}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [4*N-1:0] a = '0;
    logic [4*N-1:0] b = '0;
    logic          busy, done, err;
    logic [RW-1:0] result;

    int   checks = 0;
    int   errors = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    cl_dec_unit #(.NDIG(N)) i_cl_dec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .busy(busy), .done(done), .err(err), .result(result)
    );

    function automatic int dg(input logic [RW-1:0] v, input int i);
        return int'(v[4*i +: 4]);
    endfunction

    function automatic logic [RW-1:0] model(input logic [1:0] o, input logic [4*N-1:0] x, input logic [4*N-1:0] y);
        logic [RW-1:0] r;
        r = '0;
        if (o == 2'b11) begin
            for (int k = 0; k < RD; k++) begin
                int s;
                s = 0;
                for (int i = 0; i < N; i++) begin
                    for (int j = 0; j < N; j++) begin
                        if (i + j == k) s = s + int'(x[4*i +: 4]) * int'(y[4*j +: 4]);
                    end
                end
                r[4*k +: 4] = 4'(s % 10);
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                int xi, yi, v;
                xi = int'(x[4*i +: 4]);
                yi = int'(y[4*i +: 4]);
                if (o == 2'b00)      v = (xi + yi) % 10;
                else if (o == 2'b01) v = (xi + (10 - yi) % 10) % 10;
                else                 v = (10 - xi) % 10;
                r[4*i +: 4] = 4'(v);
            end
        end
        return r;
    endfunction

    // count digits that disagree with separate mod 2 / mod 5 convolutions
    function automatic int crt_miss(input logic [4*N-1:0] x, input logic [4*N-1:0] y, input logic [RW-1:0] r);
        int miss;
        miss = 0;
        for (int k = 0; k < RD; k++) begin
            int s2, s5;
            s2 = 0;
            s5 = 0;
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (i + j == k) begin
                        s2 = s2 + (int'(x[4*i +: 4]) % 2) * (int'(y[4*j +: 4]) % 2);
                        s5 = s5 + (int'(x[4*i +: 4]) % 5) * (int'(y[4*j +: 4]) % 5);
                    end
                end
            end
            if (dg(r, k) % 2 != s2 % 2 || dg(r, k) % 5 != s5 % 5) miss++;
        end
        return miss;
    endfunction

    task automatic chk(input string tag, input logic [RW-1:0] got, input logic [RW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [4*N-1:0] x, input logic [4*N-1:0] y,
                          output logic [RW-1:0] r, output int cyc, output logic e);
        @(negedge clk);
        op = o; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        r = result;
        e = err;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] r, r2, rn;
        int            cyc;
        logic          e;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 result", result, '0);
        chk("R11 busy/done/err", RW'({busy, done, err}), '0);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4, latency R5
        for (int v = 0; v < NV; v++) begin
            logic [1:0]     o;
            logic [4*N-1:0] x, y;
            o = VEC[v][65:64];
            x = VEC[v][63:32];
            y = VEC[v][31:0];
            run_op(o, x, y, r, cyc, e);
            case (o)
                2'b00:   chk("R1 add", r, model(o, x, y));
                2'b01:   chk("R2 sub", r, model(o, x, y));
                2'b10:   chk("R3 neg", r, model(o, x, y));
                default: chk("R4 mul", r, model(o, x, y));
            endcase
            chk("R5 latency", RW'(cyc), RW'((o == 2'b11) ? N + 1 : 1));
            chk("R8 no err on valid", RW'(e), '0);
            if (o == 2'b11) chk("R7 mod2/mod5 view", RW'(crt_miss(x, y, r)), '0);
        end

        // R4 9 x 9 gives digit 1
        run_op(2'b11, 32'h0000_0009, 32'h0000_0009, r, cyc, e);
        chk("R4 nine times nine", r, RW'(1));
        // R4 11 x 11 gives 121
        run_op(2'b11, 32'h0000_0011, 32'h0000_0011, r, cyc, e);
        chk("R4 eleven squared", r, RW'(60'h121));

        // R3 digit plus its complement is zero everywhere
        run_op(2'b10, 32'h1907_3546, 32'h0, rn, cyc, e);
        run_op(2'b00, 32'h1907_3546, rn[4*N-1:0], r, cyc, e);
        chk("R3 a plus neg a", r, '0);

        // R6 operand order
        run_op(2'b11, 32'h0000_3052, 32'h0719_0004, r, cyc, e);
        run_op(2'b11, 32'h0719_0004, 32'h0000_3052, r2, cyc, e);
        chk("R6 mul swap", r2, r);
        run_op(2'b00, 32'h2468_1357, 32'h9753_8642, r, cyc, e);
        run_op(2'b00, 32'h9753_8642, 32'h2468_1357, r2, cyc, e);
        chk("R6 add swap", r2, r);

        // R10 done pulse and hold
        run_op(2'b01, 32'h4444_4444, 32'h1212_1212, r, cyc, e);
        @(negedge clk);
        chk("R10 done one cycle", RW'(done), '0);
        chk("R10 result holds", result, r);

        // R8 invalid nibble rejected, result unchanged
        run_op(2'b00, 32'h1234_5A78, 32'h1111_1111, r2, cyc, e);
        chk("R8 err raised", RW'(e), RW'(1));
        chk("R8 err latency", RW'(cyc), RW'(1));
        chk("R8 result unchanged", r2, r);
        run_op(2'b11, 32'h1111_1111, 32'hF000_0000, r2, cyc, e);
        chk("R8 err on b", RW'(e), RW'(1));
        chk("R8 result unchanged mul", r2, r);

        // R9 start while busy ignored
        @(negedge clk);
        op = 2'b11; a = 32'h0000_0123; b = 32'h0000_0456; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op = 2'b00; a = 32'h0; b = 32'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 3;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk("R9 busy start ignored", result, model(2'b11, 32'h0000_0123, 32'h0000_0456));
        chk("R9 timing kept", RW'(cyc), RW'(N + 1));
        @(negedge clk);
        chk("R9 no second op", RW'({busy, done}), '0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule